// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic/logic stage of a small RISC core. Each cycle it takes two operands, a 4-bit operation code and the current status flags, and one clock edge later presents the result, the new status word and a mask naming the flags the operation wrote. It covers addition and subtraction with and without carry, AND/OR/XOR, one's and two's complement, increment, decrement, logical and arithmetic right shift, rotations through carry and nibble swap.

A left shift is issued by the decoder as an addition of a register to itself. A compare is issued as a subtraction (or subtraction with carry) whose result is not written back. The status word returned already merges the new flag values with the untouched ones, so the core can load it straight into its status register. The block has no states: one clocked process holds the output stage and one combinational process selects the operation with a unique case.

Top module: `alu8_core`

## Requirements
- R1: Outputs are registered. `result_o`, `flags_o` and `fmask_o` show the operation presented on the inputs at the previous rising clock edge and do not change between edges. An active-low asynchronous reset clears all three to zero. Opcodes: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 OR, 6 XOR, 7 COM, 8 NEG, 9 INC, 10 DEC, 11 LSR, 12 ROL, 13 ROR, 14 ASR, 15 SWAP.
- R2: The flag vector is laid out as bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S, bit 5 H. Every flag whose `fmask_o` bit is 0 equals the matching bit of `flags_i`.
- R3: ADD gives a+b and ADC gives a+b+C. Both write all six flags: C is the carry out of bit 7, H is the carry out of bit 3, V is two's-complement overflow, N is bit 7 of the result, and Z is set when the result is zero.
- R4: SUB gives a-b and SBC gives a-b-C. Both write all six flags: C is the borrow out of bit 7, H is the borrow into bit 4, V is signed overflow, N is result bit 7, and for SUB Z is set when the result is zero.
- R5: For SBC, Z is 1 only when the result is zero and the incoming Z was 1. A nonzero result clears Z.
- R6: AND, OR and XOR write only S, V, N and Z (mask 0x1E). V is forced to 0.
- R7: COM gives 0xFF minus a. It writes S, V, N, Z and C (mask 0x1F), with C forced to 1 and V forced to 0.
- R8: NEG gives 0x00 minus a and writes all six flags. C is set when the result is nonzero, V is set only for 0x80, and H is the borrow into bit 4.
- R9: INC and DEC write S, V, N and Z (mask 0x1E) and never C. V is set when INC starts from 0x7F or when DEC starts from 0x80.
- R10: LSR shifts a right and fills bit 7 with 0. ASR shifts a right and keeps bit 7. Both move the old bit 0 into C and write mask 0x1F.
- R11: ROL moves the incoming C into bit 0 and bit 7 into C. ROR moves the incoming C into bit 7 and bit 0 into C. Both write mask 0x1F.
- R12: For all four shifts and rotates, V equals N xor C after the operation.
- R13: SWAP exchanges the upper and lower nibbles of a. It writes no flag (mask 0), so `flags_o` equals `flags_i`.
- R14: Whenever S is written, S equals N xor V of the new flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output stage loads on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (destination register value) |
| b_i | input | 8 | Second operand (source register or constant) |
| flags_i | input | 6 | Current status flags {H,S,V,N,Z,C} |
| result_o | output | 8 | Operation result |
| flags_o | output | 6 | New status flags, merged with the untouched ones |
| fmask_o | output | 6 | Flags written by the operation |

## Verification
The bench builds the block with its default 8-bit data width and 4-bit nibble. At that width every value of the first operand can be swept for every opcode. Both carry-in values are used, and the second operand covers every repeated-nibble byte plus 0x7F and 0x80. This reaches every half-carry and overflow boundary, every zero result of the chained subtraction, and both carry polarities of each rotation. Directed vectors add the registered timing, the reset state and the Z chaining of subtraction with carry.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_COM  = 4'd7,
        OP_NEG  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_LSR  = 4'd11,
        OP_ROL  = 4'd12,
        OP_ROR  = 4'd13,
        OP_ASR  = 4'd14,
        OP_SWAP = 4'd15
    } alu_op_e;

    localparam int FLAG_W = 6;
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;

    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    localparam logic [FLAG_W-1:0] MASK_ALL   = 6'b111111;
    localparam logic [FLAG_W-1:0] MASK_SVNZC = 6'b011111;
    localparam logic [FLAG_W-1:0] MASK_SVNZ  = 6'b011110;
    localparam logic [FLAG_W-1:0] MASK_NONE  = 6'b000000;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              half_o,
    output logic              ovf_o
);
    localparam int HALF = DATA_W / 2;
    localparam int FW   = DATA_W + 1;
    localparam int HW   = HALF + 1;

    logic [DATA_W:0] full;
    logic [HALF:0]   low;
    logic            xs, ys, rs;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, x_i} - {1'b0, y_i} - FW'(cin_i);
            low  = {1'b0, x_i[HALF-1:0]} - {1'b0, y_i[HALF-1:0]} - HW'(cin_i);
        end else begin
            full = {1'b0, x_i} + {1'b0, y_i} + FW'(cin_i);
            low  = {1'b0, x_i[HALF-1:0]} + {1'b0, y_i[HALF-1:0]} + HW'(cin_i);
        end
        sum_o  = full[DATA_W-1:0];
        cout_o = full[DATA_W];
        half_o = low[HALF];
        xs     = x_i[DATA_W-1];
        ys     = y_i[DATA_W-1];
        rs     = full[DATA_W-1];
        ovf_o  = sub_i ? ((xs != ys) && (rs != xs)) : ((xs == ys) && (rs != xs));
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM:  res_o = ~a_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        cout_o = a_i[0];
        unique case (op_i)
            OP_LSR:  res_o = {1'b0, a_i[DATA_W-1:1]};
            OP_ASR:  res_o = {a_i[DATA_W-1], a_i[DATA_W-1:1]};
            OP_ROR:  res_o = {cin_i, a_i[DATA_W-1:1]};
            OP_ROL: begin
                res_o  = {a_i[DATA_W-2:0], cin_i};
                cout_o = a_i[DATA_W-1];
            end
            OP_SWAP: res_o = {a_i[HALF-1:0], a_i[DATA_W-1:HALF]};
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] fmask_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    alu_op_e           op;
    logic [DATA_W-1:0] as_x, as_y, as_sum;
    logic              as_cin, as_sub, as_cout, as_half, as_ovf;
    logic [DATA_W-1:0] lg_res, sh_res;
    logic              sh_cout;

    logic [DATA_W-1:0] nxt_res;
    logic [FLAG_W-1:0] nxt_mask, nxt_flags;
    flags_t            fl;

    assign op = alu_op_e'(op_i);

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .x_i    (as_x),
        .y_i    (as_y),
        .cin_i  (as_cin),
        .sub_i  (as_sub),
        .sum_o  (as_sum),
        .cout_o (as_cout),
        .half_o (as_half),
        .ovf_o  (as_ovf)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (lg_res)
    );

    alu8_shift #(.DATA_W(DATA_W)) u_shift (
        .op_i   (op),
        .a_i    (a_i),
        .cin_i  (flags_i[FL_C]),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    // operand steering for the shared adder/subtractor
    always_comb begin
        as_x   = a_i;
        as_y   = b_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC: as_cin = flags_i[FL_C];
            OP_SUB: as_sub = 1'b1;
            OP_SBC: begin
                as_sub = 1'b1;
                as_cin = flags_i[FL_C];
            end
            OP_NEG: begin
                as_x   = '0;
                as_y   = a_i;
                as_sub = 1'b1;
            end
            OP_INC: as_y = ONE;
            OP_DEC: begin
                as_y   = ONE;
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    // result select and flag generation
    always_comb begin
        fl       = '0;
        nxt_res  = as_sum;
        nxt_mask = MASK_NONE;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                fl.c     = as_cout;
                fl.h     = as_half;
                fl.v     = as_ovf;
                nxt_mask = MASK_ALL;
            end
            OP_INC, OP_DEC: begin
                fl.v     = as_ovf;
                nxt_mask = MASK_SVNZ;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_res  = lg_res;
                nxt_mask = MASK_SVNZ;
            end
            OP_COM: begin
                nxt_res  = lg_res;
                fl.c     = 1'b1;
                nxt_mask = MASK_SVNZC;
            end
            OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                nxt_res  = sh_res;
                fl.c     = sh_cout;
                fl.v     = sh_res[DATA_W-1] ^ sh_cout;
                nxt_mask = MASK_SVNZC;
            end
            OP_SWAP: nxt_res = sh_res;
        endcase
        fl.n = nxt_res[DATA_W-1];
        fl.z = (nxt_res == '0);
        if (op == OP_SBC) begin
            fl.z = fl.z & flags_i[FL_Z];
        end
        fl.s      = fl.n ^ fl.v;
        nxt_flags = (fl & nxt_mask) | (flags_i & ~nxt_mask);
    end

    // output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            flags_o  <= '0;
            fmask_o  <= '0;
        end else begin
            result_o <= nxt_res;
            flags_o  <= nxt_flags;
            fmask_o  <= nxt_mask;
        end
    end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic [FLAG_W-1:0] fmask_o
);
    localparam int HALF = DATA_W / 2;

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2: untouched flags pass through
    p_pass_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (((flags_o ^ $past(flags_i)) & ~fmask_o) == '0));

    // R5: subtract with carry never sets Z
    p_sbc_z_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_SBC && !$past(flags_i[FL_Z])) |-> !flags_o[FL_Z]);

    // R6: logic ops clear V and write only S V N Z
    p_logic_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_AND) |->
            (!flags_o[FL_V] && fmask_o == MASK_SVNZ && result_o == ($past(a_i) & $past(b_i))));

    // R7: complement forces carry
    p_com_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_COM) |-> (flags_o[FL_C] && !flags_o[FL_V]));

    // R9: increment and decrement leave carry alone
    p_incdec_keep_c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC)) |->
            (!fmask_o[FL_C] && flags_o[FL_C] == $past(flags_i[FL_C])));

    // R12: shifts and rotates give V = N xor C
    p_shift_v_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) >= OP_LSR && $past(op_i) <= OP_ASR) |->
            (flags_o[FL_V] == (flags_o[FL_N] ^ flags_o[FL_C])));

    // R13: swap touches no flag
    p_swap_no_flags_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_SWAP) |->
            (fmask_o == '0 && flags_o == $past(flags_i) &&
             result_o == {$past(a_i[HALF-1:0]), $past(a_i[DATA_W-1:HALF])}));

    // R14: sign flag consistency
    p_sign_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && fmask_o[FL_S]) |-> (flags_o[FL_S] == (flags_o[FL_N] ^ flags_o[FL_V])));

endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .flags_o  (flags_o),
    .fmask_o  (fmask_o)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] op_i;
    logic [7:0] a_i, b_i;
    logic [5:0] flags_i;
    logic [7:0] result_o;
    logic [5:0] flags_o, fmask_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    alu8_core u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .flags_i  (flags_i),
        .result_o (result_o),
        .flags_o  (flags_o),
        .fmask_o  (fmask_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op);
        case (op)
            0, 1:   return "R3";
            2, 3:   return "R4";
            4, 5, 6: return "R6";
            7:      return "R7";
            8:      return "R8";
            9, 10:  return "R9";
            11, 14: return "R10";
            12, 13: return "R11";
            default: return "R13";
        endcase
    endfunction

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // reference model: bit order C0 Z1 N2 V3 S4 H5
    task automatic model(input int op, input int a, input int b, input int fi,
                         output int r, output int fo, output int m);
        int ci, c, z, n, v, h, s, t, zin;
        ci = fi & 1;
        zin = (fi >> 1) & 1;
        c = 0; v = 0; h = 0;
        case (op)
            0, 1: begin
                int k;
                k = (op == 1) ? ci : 0;
                t = a + b + k;
                r = t & 255;
                c = (t > 255);
                h = (((a & 15) + (b & 15) + k) > 15);
                t = sgn(a) + sgn(b) + k;
                v = (t > 127 || t < -128);
                m = 'h3F;
            end
            2, 3, 8: begin
                int x, y, k;
                x = (op == 8) ? 0 : a;
                y = (op == 8) ? a : b;
                k = (op == 3) ? ci : 0;
                t = x - y - k;
                r = (t + 512) & 255;
                c = (t < 0);
                h = (((x & 15) - (y & 15) - k) < 0);
                t = sgn(x) - sgn(y) - k;
                v = (t > 127 || t < -128);
                m = 'h3F;
            end
            4: begin r = a & b; m = 'h1E; end
            5: begin r = a | b; m = 'h1E; end
            6: begin r = a ^ b; m = 'h1E; end
            7: begin r = 255 - a; c = 1; m = 'h1F; end
            9: begin r = (a + 1) & 255; v = (a == 127); m = 'h1E; end
            10: begin r = (a + 255) & 255; v = (a == 128); m = 'h1E; end
            11: begin r = a >> 1; c = a & 1; m = 'h1F; end
            12: begin r = ((a << 1) | ci) & 255; c = a >> 7; m = 'h1F; end
            13: begin r = (ci << 7) | (a >> 1); c = a & 1; m = 'h1F; end
            14: begin r = (a & 128) | (a >> 1); c = a & 1; m = 'h1F; end
            default: begin r = ((a & 15) << 4) | (a >> 4); m = 0; end
        endcase
        n = (r >> 7) & 1;
        if (op >= 11 && op <= 14) v = n ^ c;
        z = (r == 0);
        if (op == 3) z = z & zin;
        s = n ^ v;
        t = c | (z << 1) | (n << 2) | (v << 3) | (s << 4) | (h << 5);
        fo = (t & m) | (fi & ~m & 'h3F);
    endtask

    // drive at a falling edge, let one rising edge load, check at the next falling edge
    task automatic run_vec(input int op, input int a, input int b, input int fi);
        int er, ef, em;
        op_i    = 4'(op);
        a_i     = 8'(a);
        b_i     = 8'(b);
        flags_i = 6'(fi);
        @(posedge clk);
        @(negedge clk);
        model(op, a, b, fi, er, ef, em);
        check(result_o == 8'(er), tag_of(op), "result", result_o, er);
        check(fmask_o == 6'(em), tag_of(op), "mask", fmask_o, em);
        check(flags_o == 6'(ef), tag_of(op), "flags", flags_o, ef);
        check(((flags_o ^ 6'(fi)) & ~fmask_o) == 6'd0, "R2", "unwritten flags", flags_o, fi);
        if (fmask_o[4])
            check(flags_o[4] == (flags_o[2] ^ flags_o[3]), "R14", "S", flags_o[4],
                  flags_o[2] ^ flags_o[3]);
        if (op >= 11 && op <= 14)
            check(flags_o[3] == (flags_o[2] ^ flags_o[0]), "R12", "V", flags_o[3],
                  flags_o[2] ^ flags_o[0]);
    endtask

    initial begin
        #(150000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        op_i    = 4'd0;
        a_i     = 8'hA5;
        b_i     = 8'h5A;
        flags_i = 6'h3F;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(result_o == 8'h00, "R1", "reset result", result_o, 0);
        check(flags_o == 6'h00, "R1", "reset flags", flags_o, 0);
        check(fmask_o == 6'h00, "R1", "reset mask", fmask_o, 0);
        rst_n = 1'b1;

        // R1: output holds until the next rising edge
        run_vec(9, 8'h41, 0, 0);
        op_i = 4'd15;
        a_i  = 8'h3C;
        #2;
        check(result_o == 8'h42, "R1", "held between edges", result_o, 8'h42);
        @(posedge clk);
        @(negedge clk);
        check(result_o == 8'hC3, "R1", "loaded after edge", result_o, 8'hC3);

        // R5: Z chaining through subtract with carry
        run_vec(3, 8'h10, 8'h10, 6'b000010);
        check(flags_o[1] == 1'b1, "R5", "zero with Z in", flags_o[1], 1);
        run_vec(3, 8'h10, 8'h10, 6'b000000);
        check(flags_o[1] == 1'b0, "R5", "zero without Z in", flags_o[1], 0);
        run_vec(3, 8'h11, 8'h10, 6'b000010);
        check(flags_o[1] == 1'b0, "R5", "nonzero result", flags_o[1], 0);

        // sweep: binary ops over every a, a byte set for b, both carries
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int c = 0; c < 2; c++) begin
                    if (op <= 6) begin
                        for (int bi = 0; bi < 18; bi++) begin
                            int b, fi;
                            b  = (bi < 16) ? bi * 17 : ((bi == 16) ? 'h80 : 'h7F);
                            fi = ((((a + 3 * b) & 31) ^ (c * 21)) << 1) | c;
                            run_vec(op, a, b, fi & 'h3F);
                        end
                    end else begin
                        int fi;
                        fi = ((((a * 5) & 31) ^ (c * 21)) << 1) | c;
                        run_vec(op, a, 'h5A, fi & 'h3F);
                    end
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule